// File: doc/BRIEF.md
# Cache Block Gating Obfuscation Unit

This unit sits beside a set-associative cache and decides, for every lookup, whether a tag match may be reported as a hit. It keeps one enable bit per cache block (per set and way). Two run-time commands change those bits: one switches a block off and one switches it back on. A block that is switched off never hits, never becomes a fill victim, and a set whose ways are all off sends the access straight to the next memory level.

A 16-bit linear feedback shift register also turns some genuine hits into deliberate misses, at a rate set by a threshold input. This blurs the relation between the program's real access pattern and the timing and power that can be observed. Switching off a block that holds modified data first raises a write-back request for that block, and only then clears it and asks the cache to invalidate it.

The cache arrays and the core's instruction decode are outside the unit. The unit receives the raw per-way tag match vector, the replacement logic's preferred way and the dirty bit of the block named by a command, and it returns the filtered hit, the victim and the maintenance pulses.

Top module: `cbg_unit`

## Requirements
- R1: After reset every block of every set is enabled (`set_en` all ones for any `lk_set`), `cmd_ready` is 1 and `cmd_done`, `wb_req` and `inval_req` are 0.
- R2: A switch-off command (`cmd_op`=0) accepted in cycle T for a block that is off or clean clears that block's enable bit, so that `set_en` shows it from cycle T+1. `cmd_done` and `inval_req` pulse for one cycle in T+1, and `op_set`/`op_way` carry the command's set and way.
- R3: A switch-on command (`cmd_op`=1) accepted in cycle T sets the block's enable bit from cycle T+1 and pulses `cmd_done` in T+1 without `inval_req`.
- R4: A lookup whose tag match falls only on disabled ways reports `hit`=0. `hit_way` is the match vector ANDed with the set's enable bits when `hit`=1, and zero otherwise.
- R5: A switch-off command accepted in cycle T for an enabled block with `cmd_dirty`=1 raises `wb_req` with `op_set`/`op_way` in T+1, during which `cmd_ready` is 0 and commands are ignored. In T+2 the block is disabled and `cmd_done` and `inval_req` pulse.
- R6: When a valid lookup matches at least one enabled way and the low 8 bits of the LFSR are below `thresh`, `force_miss`=1 and `hit`=0. With `thresh`=0 no miss is ever forced.
- R7: The LFSR resets to 16'hACE1 and advances one step on each cycle with `lk_valid`=1. The new bit 0 is the XOR of bits 15, 13, 12 and 10, and the old bits 14..0 shift up by one.
- R8: `victim_way` equals `lk_pref_way` when that way is enabled in `lk_set`, otherwise the lowest-numbered enabled way, and 0 when none is enabled.
- R9: `bypass` is 1 exactly when `lk_valid`=1 and every way of `lk_set` is disabled; in that case `hit` and `force_miss` are 0.
- R10: Switching off a block that is already off never raises `wb_req`, even with `cmd_dirty`=1; it completes as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Gating command present |
| cmd_op | input | 1 | 1 = switch block on, 0 = switch block off |
| cmd_set | input | SET_W | Set index of the command |
| cmd_way | input | WAY_W | Way index of the command |
| cmd_dirty | input | 1 | Dirty bit of the block named by the command |
| cmd_ready | output | 1 | Unit can accept a command |
| cmd_done | output | 1 | One-cycle completion pulse |
| wb_req | output | 1 | Write-back request for block op_set/op_way |
| inval_req | output | 1 | Invalidate request for block op_set/op_way |
| op_set | output | SET_W | Set of the block under maintenance |
| op_way | output | WAY_W | Way of the block under maintenance |
| lk_valid | input | 1 | Lookup present |
| lk_set | input | SET_W | Lookup set index |
| lk_match | input | WAYS | Raw per-way tag match |
| lk_pref_way | input | WAY_W | Way proposed by the replacement policy |
| thresh | input | THR_W | Forced-miss threshold |
| set_en | output | WAYS | Enable bits of lk_set |
| hit | output | 1 | Filtered hit |
| hit_way | output | WAYS | Ways that hit |
| force_miss | output | 1 | Real hit converted to a miss |
| bypass | output | 1 | All ways of the set are off |
| victim_way | output | WAY_W | Fill way restricted to enabled ways |

## Verification
A wrong enable bit shows on `set_en` in the first cycle a lookup addresses that set. It then shows on `hit`, `victim_way` or `bypass` in the same cycle. A slip in the switch-off sequence shows within two cycles of the command, as a missing or misplaced `wb_req`, `inval_req` or `cmd_done` pulse, or as `cmd_ready` held low. An LFSR that advanced on the wrong cycle, or from a wrong seed, shows on the first later lookup whose forced-miss decision differs. So the bench compares every output against its model on every cycle and runs long stretches with gaps in `lk_valid`.

// File: rtl/cbg_pkg.sv
`timescale 1ns/1ps
package cbg_pkg;

    localparam int          RND_W    = 16;
    localparam logic [15:0] RND_SEED = 16'hACE1;

    typedef enum logic { OP_OFF = 1'b0, OP_ON = 1'b1 } gate_op_e;

    typedef enum logic { ST_IDLE = 1'b0, ST_FLUSH = 1'b1 } gate_state_e;

    // One step of the shift register: taps at bits 15, 13, 12, 10.
    function automatic logic [RND_W-1:0] rnd_step(input logic [RND_W-1:0] s);
        return {s[RND_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/cbg_mask.sv
`timescale 1ns/1ps
module cbg_mask
    import cbg_pkg::*;
#(
    parameter int SETS = 16,
    parameter int WAYS = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  gate_op_e         cmd_op,
    input  logic [SET_W-1:0] cmd_set,
    input  logic [WAY_W-1:0] cmd_way,
    input  logic             cmd_dirty,
    input  logic [SET_W-1:0] rd_set,
    output logic [WAYS-1:0]  rd_en,
    output logic             cmd_ready,
    output logic             done,
    output logic             wb_req,
    output logic             inval,
    output logic [SET_W-1:0] op_set,
    output logic [WAY_W-1:0] op_way
);

    logic [SETS-1:0][WAYS-1:0] en_q;
    gate_state_e               state_q;
    logic                      done_q, wb_q, inval_q;
    logic [SET_W-1:0]          set_q;
    logic [WAY_W-1:0]          way_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '1;
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
            wb_q    <= 1'b0;
            inval_q <= 1'b0;
            set_q   <= '0;
            way_q   <= '0;
        end else begin
            done_q  <= 1'b0;
            wb_q    <= 1'b0;
            inval_q <= 1'b0;
            case (state_q)
                ST_FLUSH: begin
                    en_q[set_q][way_q] <= 1'b0;
                    inval_q            <= 1'b1;
                    done_q             <= 1'b1;
                    state_q            <= ST_IDLE;
                end
                default: begin
                    if (cmd_valid) begin
                        set_q <= cmd_set;
                        way_q <= cmd_way;
                        if (cmd_op == OP_ON) begin
                            en_q[cmd_set][cmd_way] <= 1'b1;
                            done_q                 <= 1'b1;
                        end else if (en_q[cmd_set][cmd_way] && cmd_dirty) begin
                            wb_q    <= 1'b1;
                            state_q <= ST_FLUSH;
                        end else begin
                            en_q[cmd_set][cmd_way] <= 1'b0;
                            done_q                 <= 1'b1;
                            inval_q                <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign rd_en     = en_q[rd_set];
    assign cmd_ready = (state_q == ST_IDLE);
    assign done      = done_q;
    assign wb_req    = wb_q;
    assign inval     = inval_q;
    assign op_set    = set_q;
    assign op_way    = way_q;

endmodule

// File: rtl/cbg_rnd.sv
`timescale 1ns/1ps
module cbg_rnd
    import cbg_pkg::*;
#(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic [THR_W-1:0] thresh,
    output logic             below
);

    logic [RND_W-1:0] s_q;

    always_ff @(posedge clk) begin
        if (rst)      s_q <= RND_SEED;
        else if (adv) s_q <= rnd_step(s_q);
    end

    assign below = (s_q[THR_W-1:0] < thresh);

endmodule

// File: rtl/cbg_lookup.sv
`timescale 1ns/1ps
module cbg_lookup #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             lk_valid,
    input  logic [WAYS-1:0]  match,
    input  logic [WAYS-1:0]  en,
    input  logic [WAY_W-1:0] pref,
    input  logic             rnd_below,
    output logic             hit,
    output logic [WAYS-1:0]  hit_way,
    output logic             force_miss,
    output logic             bypass,
    output logic [WAY_W-1:0] victim
);

    logic [WAYS-1:0] live;
    logic            any_live;

    assign live       = match & en;
    assign any_live   = lk_valid && (live != '0);
    assign force_miss = any_live && rnd_below;
    assign hit        = any_live && !rnd_below;
    assign hit_way    = hit ? live : '0;
    assign bypass     = lk_valid && (en == '0);

    always_comb begin
        victim = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (en[i]) victim = WAY_W'(i);
        end
        if (en[pref]) victim = pref;
    end

endmodule

// File: rtl/cbg_unit.sv
`timescale 1ns/1ps
module cbg_unit
    import cbg_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int THR_W = 8,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic             cmd_op,
    input  logic [SET_W-1:0] cmd_set,
    input  logic [WAY_W-1:0] cmd_way,
    input  logic             cmd_dirty,
    output logic             cmd_ready,
    output logic             cmd_done,
    output logic             wb_req,
    output logic             inval_req,
    output logic [SET_W-1:0] op_set,
    output logic [WAY_W-1:0] op_way,
    input  logic             lk_valid,
    input  logic [SET_W-1:0] lk_set,
    input  logic [WAYS-1:0]  lk_match,
    input  logic [WAY_W-1:0] lk_pref_way,
    input  logic [THR_W-1:0] thresh,
    output logic [WAYS-1:0]  set_en,
    output logic             hit,
    output logic [WAYS-1:0]  hit_way,
    output logic             force_miss,
    output logic             bypass,
    output logic [WAY_W-1:0] victim_way
);

    logic rnd_below;

    cbg_mask #(.SETS(SETS), .WAYS(WAYS)) i_mask (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (gate_op_e'(cmd_op)),
        .cmd_set   (cmd_set),
        .cmd_way   (cmd_way),
        .cmd_dirty (cmd_dirty),
        .rd_set    (lk_set),
        .rd_en     (set_en),
        .cmd_ready (cmd_ready),
        .done      (cmd_done),
        .wb_req    (wb_req),
        .inval     (inval_req),
        .op_set    (op_set),
        .op_way    (op_way)
    );

    cbg_rnd #(.THR_W(THR_W)) i_rnd (
        .clk    (clk),
        .rst    (rst),
        .adv    (lk_valid),
        .thresh (thresh),
        .below  (rnd_below)
    );

    cbg_lookup #(.WAYS(WAYS)) i_lookup (
        .lk_valid   (lk_valid),
        .match      (lk_match),
        .en         (set_en),
        .pref       (lk_pref_way),
        .rnd_below  (rnd_below),
        .hit        (hit),
        .hit_way    (hit_way),
        .force_miss (force_miss),
        .bypass     (bypass),
        .victim     (victim_way)
    );

endmodule

// File: rtl/cbg_unit_chk.sv
`timescale 1ns/1ps
module cbg_unit_chk #(
    parameter int WAYS  = 4,
    parameter int THR_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             cmd_done,
    input logic             wb_req,
    input logic             inval_req,
    input logic [THR_W-1:0] thresh,
    input logic [WAYS-1:0]  set_en,
    input logic             hit,
    input logic [WAYS-1:0]  hit_way,
    input logic             force_miss,
    input logic             bypass
);

    // R4
    hit_on_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> ((hit_way & ~set_en) == '0));

    // R6
    hit_force_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(hit && force_miss));

    // R6
    zero_thresh_chk: assert property (@(posedge clk) disable iff (rst)
        (thresh == '0) |-> !force_miss);

    // R9
    bypass_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        bypass |-> (!hit && !force_miss));

    // R5
    wb_then_done_chk: assert property (@(posedge clk) disable iff (rst)
        wb_req |=> (cmd_done && inval_req));

    // R5
    busy_is_wb_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_ready |-> wb_req);

    // R2
    done_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_done |-> ($past(cmd_valid && cmd_ready) || $past(wb_req)));

endmodule

bind cbg_unit cbg_unit_chk #(.WAYS(WAYS), .THR_W(THR_W)) i_cbg_unit_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_done   (cmd_done),
    .wb_req     (wb_req),
    .inval_req  (inval_req),
    .thresh     (thresh),
    .set_en     (set_en),
    .hit        (hit),
    .hit_way    (hit_way),
    .force_miss (force_miss),
    .bypass     (bypass)
);

// File: tb/test_cbg_unit.sv
`timescale 1ns/1ps
module test_cbg_unit;

    localparam int SETS = 16;
    localparam int WAYS = 4;
    localparam int SW   = 4;
    localparam int WW   = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 0, cmd_op = 0, cmd_dirty = 0;
    logic [SW-1:0] cmd_set = 0;
    logic [WW-1:0] cmd_way = 0;
    logic          cmd_ready, cmd_done, wb_req, inval_req;
    logic [SW-1:0] op_set;
    logic [WW-1:0] op_way;
    logic          lk_valid = 0;
    logic [SW-1:0] lk_set = 0;
    logic [3:0]    lk_match = 0;
    logic [WW-1:0] lk_pref_way = 0;
    logic [7:0]    thresh = 0;
    logic [3:0]    set_en, hit_way;
    logic          hit, force_miss, bypass;
    logic [WW-1:0] victim_way;

    always #2.5 clk = ~clk;

    cbg_unit #(.SETS(SETS), .WAYS(WAYS), .THR_W(8)) i_cbg_unit (.*);

    int n_checks = 0;
    int n_errors = 0;

    // reference model state
    bit          m_en [SETS][WAYS];
    logic [15:0] m_rnd;
    bit          m_done, m_wb, m_inval, m_pend, m_live;
    int          m_ps, m_pw;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int exp_en(input int s);
        int v = 0;
        for (int w = 0; w < WAYS; w++) if (m_en[s][w]) v |= (1 << w);
        return v;
    endfunction

    task automatic compare();
        int en, live, vic;
        bit below, e_hit, e_force, e_byp;
        en    = exp_en(lk_set);
        live  = en & lk_match;
        below = (m_rnd[7:0] < thresh);
        e_force = lk_valid && live != 0 && below;
        e_hit   = lk_valid && live != 0 && !below;
        e_byp   = lk_valid && en == 0;
        vic = 0;
        for (int w = WAYS - 1; w >= 0; w--) if (en[w]) vic = w;
        if (en[lk_pref_way]) vic = lk_pref_way;
        chk(set_en == en,        "R2", "set_en", set_en, en);
        chk(hit == e_hit,        "R4", "hit", hit, e_hit);
        chk(hit_way == (e_hit ? live : 0), "R4", "hit_way", hit_way, e_hit ? live : 0);
        chk(force_miss == e_force, "R6 R7", "force_miss", force_miss, e_force);
        chk(bypass == e_byp,     "R9", "bypass", bypass, e_byp);
        chk(victim_way == vic,   "R8", "victim_way", victim_way, vic);
        chk(cmd_done == m_done,  "R2", "cmd_done", cmd_done, m_done);
        chk(wb_req == m_wb,      "R5", "wb_req", wb_req, m_wb);
        chk(inval_req == m_inval, "R2", "inval_req", inval_req, m_inval);
        chk(cmd_ready == !m_pend, "R5", "cmd_ready", cmd_ready, !m_pend);
        if (m_wb || m_inval) begin
            chk(op_set == m_ps, "R5", "op_set", op_set, m_ps);
            chk(op_way == m_pw, "R5", "op_way", op_way, m_pw);
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            foreach (m_en[s, w]) m_en[s][w] = 1;
            m_rnd = 16'hACE1;
            {m_done, m_wb, m_inval, m_pend} = '0;
            m_ps = 0; m_pw = 0;
            m_live = 1;
        end else begin
            {m_done, m_wb, m_inval} = '0;
            if (m_pend) begin
                m_en[m_ps][m_pw] = 0;
                m_inval = 1; m_done = 1; m_pend = 0;
            end else if (cmd_valid) begin
                m_ps = cmd_set; m_pw = cmd_way;
                if (cmd_op) begin
                    m_en[m_ps][m_pw] = 1; m_done = 1;
                end else if (m_en[m_ps][m_pw] && cmd_dirty) begin
                    m_wb = 1; m_pend = 1;
                end else begin
                    m_en[m_ps][m_pw] = 0; m_done = 1; m_inval = 1;
                end
            end
            if (lk_valid) m_rnd = {m_rnd[14:0], m_rnd[15] ^ m_rnd[13] ^ m_rnd[12] ^ m_rnd[10]};
        end
    endtask

    // inputs are already set (at a negedge); compare, take the edge, return at negedge
    task automatic tick();
        #1;
        if (!rst && m_live) compare();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle();
        cmd_valid = 0; lk_valid = 0;
    endtask

    task automatic look(input int s, input int m, input int p);
        lk_valid = 1; lk_set = SW'(s); lk_match = 4'(m); lk_pref_way = WW'(p);
    endtask

    task automatic cmd(input bit on, input int s, input int w, input bit d);
        cmd_valid = 1; cmd_op = on; cmd_set = SW'(s); cmd_way = WW'(w); cmd_dirty = d;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) tick();
        rst = 0;
        // R1: reset state
        look(9, 0, 0); #1;
        chk(set_en == 4'hF && cmd_ready && !cmd_done && !wb_req && !inval_req,
            "R1", "reset state", set_en, 15);
        tick();
        // baseline hit
        look(3, 4'b0010, 1); tick();
        // R2: clean switch-off of set 3 way 1
        idle(); cmd(0, 3, 1, 0); tick();
        cmd_valid = 0; look(3, 4'b0010, 1); #1;
        chk(cmd_done && inval_req && set_en == 4'b1101, "R2", "off completes", set_en, 13);
        // R4: match only on disabled way gives no hit
        chk(!hit, "R4", "hit on disabled way", hit, 0);
        // R8: preferred way 1 is off, lowest enabled is 0
        chk(victim_way == 0, "R8", "victim", victim_way, 0);
        tick();
        // R3: switch back on
        idle(); cmd(1, 3, 1, 0); tick();
        cmd_valid = 0; look(3, 4'b0010, 1); #1;
        chk(cmd_done && !inval_req && hit, "R3", "on restores hit", hit, 1);
        tick();
        // R5: dirty switch-off of set 5 way 2
        idle(); cmd(0, 5, 2, 1); tick();
        cmd(1, 6, 0, 0); #1;   // ignored while busy
        chk(wb_req && !cmd_ready && op_set == 5 && op_way == 2, "R5", "write-back", wb_req, 1);
        tick();
        idle(); look(6, 4'b0001, 0); #1;
        chk(cmd_done && inval_req && set_en == 4'hF, "R5", "flush done, busy cmd ignored", set_en, 15);
        tick();
        // R10: dirty switch-off of an already-off block
        idle(); cmd(0, 5, 2, 1); tick();
        cmd_valid = 0; #1;
        chk(!wb_req && cmd_done, "R10", "no write-back", wb_req, 0);
        tick();
        // R9: switch off all ways of set 7
        for (int w = 0; w < WAYS; w++) begin
            idle(); cmd(0, 7, w, 0); tick();
        end
        idle(); look(7, 4'b1111, 2); #1;
        chk(bypass && !hit && victim_way == 0, "R9", "bypass", bypass, 1);
        tick();
        // R6: threshold at maximum forces most hits to misses
        thresh = 8'd255; look(3, 4'b0001, 0); tick(); tick();
        // R7 and the rest: long mixed stretch with lookup gaps
        for (int c = 0; c < 600; c++) begin
            if (c % 75 == 0) thresh = 8'(($urandom % 4) * 80);
            lk_valid    = ($urandom % 4) != 0;
            lk_set      = SW'($urandom % 8);
            lk_match    = 4'($urandom);
            lk_pref_way = WW'($urandom);
            cmd_valid   = ($urandom % 3) == 0;
            cmd_op      = ($urandom % 2) == 0;
            cmd_set     = SW'($urandom % 8);
            cmd_way     = WW'($urandom);
            cmd_dirty   = ($urandom % 2) == 0;
            tick();
        end
        idle(); tick();
        summary();
        $finish;
    end

endmodule